// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability and Write Generator

This block turns a device's internal interrupt events into memory-write requests, so that no interrupt wire is needed. Software programs a small capability register set through a word-wide configuration port: a 16-bit control word, a message address that may be presented as 32 or 64 bits, and a message data word. Once the block is enabled, each event on one of its source lines produces exactly one write request on a valid/ready interface. The request carries the programmed address and the programmed data word, with the low data bits replaced by the source number when more than one message is enabled.

The number of enabled messages is an encoded power of two. The code is held at or below the capability that the block was built with. Events that arrive while the block is disabled wait in a pending flag per source. Pending sources are served in round-robin order once the block is enabled. A request, once raised, stays fixed until the receiver accepts it.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset, the control word reads `{8'h00, ADDR64, 3'b000, MMC_CAP, 1'b0}`, the low address word reads `32'hFEE0_0000`, the high address word and the data word read zero, and `req_valid` is 0. Register select codes: 0 = control, 1 = low address, 2 = high address, 3 = data. `cfg_rdata` follows `cfg_addr` combinationally.
- R2: In the control word, bit 0 (enable) can be written. Bits 3:1 (capability code), bit 7 (64-bit capable) and bits 15:8 ignore writes and always read `MMC_CAP`, `ADDR64` and zero. Bits 31:16 of `cfg_rdata` read zero.
- R3: A write to the enabled-count code in control bits 6:4 stores the smaller of the written code and `MMC_CAP`. Codes 0..5 mean 1, 2, 4, 8, 16 and 32 messages.
- R4: The low address word always reads `12'hFEE` in bits 31:20. Bits 19:12 (destination), bit 3 (redirection hint) and bit 2 (destination mode) can be written. All other bits read zero.
- R5: The high address word always reads zero and ignores writes.
- R6: In the data word, bits 7:0 (vector), 10:8 (delivery mode), 14 (level) and 15 (trigger mode) can be written. All other bits read zero.
- R7: No request is raised while the enable bit is 0. Events received meanwhile stay pending and are issued after enable is set.
- R8: A request carries `req_addr = {32'h0, low address word}`. Its data is the data word with bits `k < code` replaced by bit k of the source index. With code 0, every source sends the data word unchanged.
- R9: When several sources are pending, grants go round-robin, starting after the source most recently granted (source 0 first after reset).
- R10: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr` and `req_data` hold their values.
- R11: A pulse sets its source's pending flag. Further pulses on the same source before that flag is granted merge into one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| src_pulse | input | NUM_SRC | One-cycle event per interrupt source |
| req_valid | output | 1 | Write request present |
| req_ready | input | 1 | Receiver accepts the request |
| req_addr | output | 64 | Message address |
| req_data | output | 32 | Message data |

## Verification
Configuration state faults appear on `cfg_rdata` in the same cycle the register is selected. A corrupted round-robin pointer shows as a wrong source number in the low data bits of the next granted request. A lost or doubled pending flag shows as a missing or extra accepted request within a few cycles of enabling. A behavioural model in the bench follows every clock, so any divergence in valid, address or data is reported in the cycle it first appears.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_ADDR_LO = 2'd1,
        SEL_ADDR_HI = 2'd2,
        SEL_DATA    = 2'd3
    } reg_sel_e;

    localparam logic [11:0] ADDR_TOP   = 12'hFEE;
    localparam logic [31:0] ADDR_WMASK = 32'h000F_F00C;
    localparam logic [31:0] DATA_WMASK = 32'h0000_C7FF;
    localparam int          NUM_BITS_W = 5;

    typedef struct packed {
        logic [7:0] rsvd;
        logic       addr64;
        logic [2:0] cnt_en;
        logic [2:0] cnt_cap;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } wr_req_t;

    function automatic logic [2:0] clamp_count(input logic [2:0] req,
                                               input logic [2:0] cap);
        return (req > cap) ? cap : req;
    endfunction

    function automatic logic [31:0] merge_number(input logic [31:0] base,
                                                 input logic [2:0]  code,
                                                 input logic [NUM_BITS_W-1:0] num);
        logic [31:0] r;
        r = base;
        for (int k = 0; k < NUM_BITS_W; k++) begin
            if (k < int'(code)) r[k] = num[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
#(
    parameter logic [2:0] MMC_CAP = 3'd3,
    parameter bit         ADDR64  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output ctrl_t       ctrl,
    output logic [31:0] addr_lo,
    output logic [31:0] data_word
);
    logic        en_q;
    logic [2:0]  cnt_q;
    logic [31:0] addr_q;
    logic [31:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cnt_q  <= 3'd0;
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(sel))
                SEL_CTRL: begin
                    en_q  <= wdata[0];
                    cnt_q <= clamp_count(wdata[6:4], MMC_CAP);
                end
                SEL_ADDR_LO: addr_q <= wdata & ADDR_WMASK;
                SEL_DATA:    data_q <= wdata & DATA_WMASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        ctrl.rsvd    = 8'h00;
        ctrl.addr64  = ADDR64;
        ctrl.cnt_en  = cnt_q;
        ctrl.cnt_cap = MMC_CAP;
        ctrl.en      = en_q;
    end

    assign addr_lo   = {ADDR_TOP, addr_q[19:0]};
    assign data_word = data_q;

    always_comb begin
        case (reg_sel_e'(sel))
            SEL_CTRL:    rdata = {16'h0000, ctrl};
            SEL_ADDR_LO: rdata = addr_lo;
            SEL_ADDR_HI: rdata = 32'h0;
            default:     rdata = data_q;
        endcase
    end
endmodule

// File: rtl/msi_rr_pick.sv
module msi_rr_pick #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pulse,
    input  logic               take,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    logic [NUM_SRC-1:0] pend_q;
    logic [IDX_W-1:0]   last_q;
    logic               found;
    int                 c;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        c     = 0;
        for (int off = 1; off <= NUM_SRC; off++) begin
            c = int'(last_q) + off;
            if (c >= NUM_SRC) c = c - NUM_SRC;
            if (!found && pend_q[c]) begin
                found = 1'b1;
                idx   = IDX_W'(c);
            end
        end
    end

    assign any = found;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            last_q <= IDX_W'(NUM_SRC - 1);
        end else begin
            if (take) begin
                pend_q <= (pend_q & ~(NUM_SRC'(1) << idx)) | pulse;
                last_q <= idx;
            end else begin
                pend_q <= pend_q | pulse;
            end
        end
    end
endmodule

// File: rtl/msi_req_hold.sv
module msi_req_hold
    import msi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  wr_req_t next,
    input  logic    ready,
    output logic    valid,
    output wr_req_t req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            req   <= '0;
        end else if (valid) begin
            if (ready) valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            req   <= next;
        end
    end
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
    import msi_pkg::*;
#(
    parameter int         NUM_SRC = 8,
    parameter logic [2:0] MMC_CAP = 3'd3,
    parameter bit         ADDR64  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [63:0]        req_addr,
    output logic [31:0]        req_data
);
    localparam int IDX_W = $clog2(NUM_SRC);

    ctrl_t            ctrl;
    logic [31:0]      addr_lo;
    logic [31:0]      data_word;
    logic             any_pend;
    logic [IDX_W-1:0] grant;
    logic             issue;
    wr_req_t          next_req;
    wr_req_t          cur_req;

    msi_cfg_regs #(.MMC_CAP(MMC_CAP), .ADDR64(ADDR64)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .sel(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl(ctrl),
        .addr_lo(addr_lo), .data_word(data_word)
    );

    msi_rr_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .clk(clk), .rst(rst), .pulse(src_pulse), .take(issue),
        .any(any_pend), .idx(grant)
    );

    assign issue = !req_valid && ctrl.en && any_pend;

    always_comb begin
        next_req.addr = {32'h0, addr_lo};
        next_req.data = merge_number(data_word, ctrl.cnt_en, NUM_BITS_W'(grant));
    end

    msi_req_hold u_hold (
        .clk(clk), .rst(rst), .load(issue), .next(next_req),
        .ready(req_ready), .valid(req_valid), .req(cur_req)
    );

    assign req_addr = cur_req.addr;
    assign req_data = cur_req.data;
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic [31:0] req_data,
    input logic        msi_en,
    input logic [2:0]  cnt_en,
    input logic [2:0]  cnt_cap
);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

    p_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(msi_en));

    p_addr_form_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[63:32] == 32'h0 && req_addr[31:20] == 12'hFEE && req_addr[1:0] == 2'b00));

    p_count_clamp_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_en <= cnt_cap);

    p_data_rsvd_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_data[31:16] == 16'h0 && req_data[13:11] == 3'b000));
endmodule

bind msi_msg_gen msi_msg_gen_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .msi_en(ctrl.en),
    .cnt_en(ctrl.cnt_en), .cnt_cap(ctrl.cnt_cap)
);

// File: tb/sim_msi_msg_gen.sv
module sim_msi_msg_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [NS-1:0] src_pulse = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [63:0] req_addr;
    logic [31:0] req_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_msg_gen #(.NUM_SRC(NS), .MMC_CAP(3'd3), .ADDR64(1'b1)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_pulse(src_pulse),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data)
    );

    // behavioural reference model
    bit          m_en;
    int          m_cnt;
    logic [31:0] m_alo, m_data;
    bit          m_pend[NS];
    int          m_last;
    bit          m_valid;
    logic [63:0] m_raddr;
    logic [31:0] m_rdata;
    logic [31:0] acc_q[$];

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return 32'h0000_0086 | (m_en ? 32'h1 : 32'h0) | (32'(m_cnt) << 4);
            2'd1: return 32'hFEE0_0000 | m_alo;
            2'd2: return 32'h0;
            default: return m_data;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_cnt = 0; m_alo = 0; m_data = 0; m_last = NS - 1;
            m_valid = 0; m_raddr = 0; m_rdata = 0;
            for (int i = 0; i < NS; i++) m_pend[i] = 0;
        end else begin
            if (m_valid && req_ready) m_valid = 0;
            else if (!m_valid && m_en) begin
                for (int off = 1; off <= NS; off++) begin
                    int c;
                    c = (m_last + off) % NS;
                    if (!m_valid && m_pend[c]) begin
                        m_valid = 1;
                        m_pend[c] = 0;
                        m_last = c;
                        m_raddr = {32'h0, 32'hFEE0_0000 | m_alo};
                        m_rdata = m_data;
                        for (int k = 0; k < 5; k++)
                            if (k < m_cnt) m_rdata[k] = ((c >> k) & 1) != 0;
                    end
                end
            end
            for (int i = 0; i < NS; i++) if (src_pulse[i]) m_pend[i] = 1;
            if (cfg_wr) begin
                case (cfg_addr)
                    2'd0: begin
                        m_en = cfg_wdata[0];
                        m_cnt = (int'(cfg_wdata[6:4]) > 3) ? 3 : int'(cfg_wdata[6:4]);
                    end
                    2'd1: m_alo = cfg_wdata & 32'h000F_F00C;
                    2'd3: m_data = cfg_wdata & 32'h0000_C7FF;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(req_valid == m_valid, "R10 model valid", 64'(req_valid), 64'(m_valid));
            if (m_valid) begin
                chk(req_addr == m_raddr, "R8 model addr", req_addr, m_raddr);
                chk(req_data == m_rdata, "R8 model data", 64'(req_data), 64'(m_rdata));
            end
            chk(cfg_rdata == m_read(cfg_addr), "R2 model readback", 64'(cfg_rdata), 64'(m_read(cfg_addr)));
            if (req_valid && req_ready) acc_q.push_back(req_data);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cfg_addr = a; #1;
        chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        src_pulse = m; step(); src_pulse = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] ha;
        logic [31:0] hd;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        rd(2'd0, 32'h0000_0086, "R1 ctrl reset");
        rd(2'd1, 32'hFEE0_0000, "R1 addr_lo reset");
        rd(2'd2, 32'h0, "R1 addr_hi reset");
        rd(2'd3, 32'h0, "R1 data reset");
        chk(req_valid == 1'b0, "R1 valid reset", 64'(req_valid), 64'd0);
        // R2 / R3 control fields and clamp
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'h0000_00B7, "R3 clamp to capability");
        wr(2'd0, 32'h0000_0020);
        rd(2'd0, 32'h0000_00A6, "R2 enable cleared, code kept");
        // R4 / R5 / R6 masks
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 32'hFEEF_F00C, "R4 address mask");
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, 32'h0, "R5 high address zero");
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, 32'h0000_C7FF, "R6 data mask");
        wr(2'd1, 32'h0001_2008);
        wr(2'd3, 32'h0000_4030);
        // R7 held while disabled
        pulse(8'h20);
        for (int i = 0; i < 5; i++) begin
            chk(req_valid == 1'b0, "R7 no request while disabled", 64'(req_valid), 64'd0);
            step();
        end
        wr(2'd0, 32'h0000_0021);
        step();
        chk(req_valid == 1'b1, "R7 pending issued after enable", 64'(req_valid), 64'd1);
        chk(req_data == 32'h0000_4031, "R8 number in low two bits", 64'(req_data), 64'h4031);
        chk(req_addr == 64'h0000_0000_FEE1_2008, "R8 address", req_addr, 64'h0000_0000_FEE1_2008);
        // R10 hold
        ha = req_addr; hd = req_data;
        repeat (3) step();
        chk(req_valid && req_addr == ha && req_data == hd, "R10 held without ready",
            {req_data, 32'(req_valid)}, {hd, 32'd1});
        req_ready = 1'b1;
        repeat (3) step();
        // R9 round robin, last grant was 5
        wr(2'd0, 32'h0000_0031);
        acc_q.delete();
        pulse(8'b0100_1010);
        repeat (12) step();
        chk(acc_q.size() == 3, "R9 three grants", 64'(acc_q.size()), 64'd3);
        if (acc_q.size() == 3) begin
            chk(acc_q[0][2:0] == 3'd6, "R9 first grant", 64'(acc_q[0][2:0]), 64'd6);
            chk(acc_q[1][2:0] == 3'd1, "R9 second grant", 64'(acc_q[1][2:0]), 64'd1);
            chk(acc_q[2][2:0] == 3'd3, "R9 third grant", 64'(acc_q[2][2:0]), 64'd3);
        end
        // R8 single message shares the vector
        wr(2'd0, 32'h0000_0001);
        acc_q.delete();
        pulse(8'b1000_0100);
        repeat (10) step();
        chk(acc_q.size() == 2, "R8 single-message count", 64'(acc_q.size()), 64'd2);
        foreach (acc_q[i])
            chk(acc_q[i] == 32'h0000_4030, "R8 single-message vector", 64'(acc_q[i]), 64'h4030);
        // R11 merged pulses
        wr(2'd0, 32'h0000_0030);
        pulse(8'h10);
        step();
        pulse(8'h10);
        acc_q.delete();
        wr(2'd0, 32'h0000_0031);
        repeat (10) step();
        chk(acc_q.size() == 1, "R11 merged into one request", 64'(acc_q.size()), 64'd1);
        if (acc_q.size() == 1)
            chk(acc_q[0] == 32'h0000_4034, "R11 request data", 64'(acc_q[0]), 64'h4034);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule